// File: doc/BRIEF.md
# Timing Event Generator Sequencer

This block sits in the event clock domain of a timing master. A free-running counter divides the event clock down to the machine repetition rate. With the default length of 1,620,000 event clocks, an 81 MHz event clock gives a 50 Hz machine cycle. Every machine cycle starts with a cycle-start marker code. After the marker, the block plays out a programmed table of 8-bit event codes. Each code appears in exactly one event-clock slot, at the offset stored with it.

Alongside the event codes, an independent 8-bit distributed bus is sampled from external inputs on every event clock. Each clock the block presents one pair, event code plus distributed-bus byte, for a downstream serializer.

The timing controller is a two-state machine:
- `PH_SLOT` covers ordinary slots. It moves to `PH_MARK` when the count wraps from its last value to zero.
- `PH_MARK` is the slot at offset zero. It always moves to `PH_SLOT` on the next clock.

Reset places the controller in `PH_SLOT` at the last count. The first clock after reset therefore wraps straight into a new cycle.

Top module: `egs_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high), `ev_code`, `dbus_out`, `cycle_start` and `collision` are held at zero and every table entry is disabled. The first `cycle_start` appears on the second rising edge after `rst` falls.
- R2: `cycle_start` is high for exactly one clock and repeats every `CYCLE_LEN` clocks.
- R3: In the clock where `cycle_start` is high, `ev_code` is 8'h7F, the cycle-start marker.
- R4: An enabled entry with offset k, where 1 <= k <= `CYCLE_LEN`-1, places its code on `ev_code` k clocks after `cycle_start`.
- R5: In any slot other than slot 0 where no enabled entry matches, `ev_code` is 8'h00 (no event).
- R6: When two or more enabled entries share a nonzero offset, the entry with the lowest index is emitted and the others are dropped. `collision` is then set and stays high until reset.
- R7: An enabled entry with offset 0 is never emitted, because the marker takes slot 0. Such an entry sets `collision`.
- R8: `dbus_out` equals the `dbus_in` value sampled at the previous rising edge, on every clock, whatever the event codes are.
- R9: A write stores `{seq_wr_valid, seq_wr_offset, seq_wr_code}` into entry `seq_wr_idx` at a rising edge. A disabled entry, or one whose offset is `CYCLE_LEN` or more, never emits.
- R10: `collision` stays low while no slot has more than one match and no entry sits at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| dbus_in | input | 8 | Distributed-bus input bits |
| seq_wr_en | input | 1 | Table write strobe |
| seq_wr_idx | input | IDX_W | Table entry index to write |
| seq_wr_valid | input | 1 | Enable bit for the written entry |
| seq_wr_offset | input | CNT_W | Slot offset from cycle start |
| seq_wr_code | input | 8 | Event code of the entry |
| ev_code | output | 8 | Event code for this slot |
| dbus_out | output | 8 | Distributed-bus byte for this slot |
| cycle_start | output | 1 | One-clock machine cycle start strobe |
| collision | output | 1 | Sticky offset-collision flag |

## Verification
The period and marker assertions assume `CYCLE_LEN` is at least 2, so that slot 0 and the last slot are distinct. The bench uses a short cycle of 20 slots with 8 entries so that it can watch whole cycles.

The collision-persistence property assumes that only reset clears the flag. The bench changes the table only between cycles it inspects, so that each inspected cycle is played from one fixed table. Its expected codes and collision flag come from a shadow copy of the writes it made.

// File: rtl/egs_pkg.sv
package egs_pkg;
    typedef logic [7:0] evcode_t;

    localparam evcode_t EV_NONE = 8'h00;
    localparam evcode_t EV_MARK = 8'h7F;

    typedef enum logic {
        PH_MARK = 1'b0,
        PH_SLOT = 1'b1
    } phase_e;
endpackage

// File: rtl/egs_divider.sv
module egs_divider
    import egs_pkg::*;
#(
    parameter int CYCLE_LEN = 1620000,
    parameter int CNT_W     = $clog2(CYCLE_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] slot_o,
    output phase_e           phase_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    phase_e           ph_q, ph_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_SLOT;
            cnt_q <= LAST;
        end else begin
            ph_q  <= ph_nx;
            cnt_q <= cnt_nx;
        end
    end

    // next-state logic
    always_comb begin
        ph_nx  = ph_q;
        cnt_nx = cnt_q + ONE;
        unique case (ph_q)
            PH_MARK: begin
                ph_nx = PH_SLOT;
            end
            PH_SLOT: begin
                if (cnt_q == LAST) begin
                    ph_nx  = PH_MARK;
                    cnt_nx = '0;
                end
            end
            default: begin
                ph_nx  = PH_SLOT;
                cnt_nx = LAST;
            end
        endcase
    end

    assign slot_o  = cnt_q;
    assign phase_o = ph_q;
endmodule

// File: rtl/egs_seq_table.sv
module egs_seq_table
    import egs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 21,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [CNT_W-1:0] wr_offset,
    input  evcode_t          wr_code,
    input  logic [CNT_W-1:0] slot,
    output logic             hit,
    output evcode_t          hit_code,
    output logic             multi
);
    logic             ent_v   [DEPTH];
    logic [CNT_W-1:0] ent_off [DEPTH];
    evcode_t          ent_code[DEPTH];
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            ent_v[wr_idx]    <= wr_valid;
            ent_off[wr_idx]  <= wr_offset;
            ent_code[wr_idx] <= wr_code;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_off[g] == slot);
    end

    // lowest index has priority; more than one match flags a collision
    always_comb begin
        logic seen;
        seen     = 1'b0;
        multi    = 1'b0;
        hit_code = EV_NONE;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_code = ent_code[i];
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                if (seen) multi = 1'b1;
                seen = 1'b1;
            end
        end
        hit = seen;
    end
endmodule

// File: rtl/egs_frame_out.sv
module egs_frame_out
    import egs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_e  phase,
    input  logic    hit,
    input  evcode_t hit_code,
    input  logic    multi,
    input  evcode_t dbus_in,
    output evcode_t ev_code,
    output evcode_t dbus_out,
    output logic    cycle_start,
    output logic    collision
);
    evcode_t code_nx;
    logic    strobe_nx;
    logic    coll_set;

    // output decode per phase
    always_comb begin
        code_nx   = EV_NONE;
        strobe_nx = 1'b0;
        coll_set  = 1'b0;
        unique case (phase)
            PH_MARK: begin
                code_nx   = EV_MARK;
                strobe_nx = 1'b1;
                coll_set  = hit;
            end
            PH_SLOT: begin
                code_nx  = hit ? hit_code : EV_NONE;
                coll_set = multi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_code     <= EV_NONE;
            dbus_out    <= '0;
            cycle_start <= 1'b0;
            collision   <= 1'b0;
        end else begin
            ev_code     <= code_nx;
            dbus_out    <= dbus_in;
            cycle_start <= strobe_nx;
            collision   <= collision | coll_set;
        end
    end
endmodule

// File: rtl/egs_sequencer.sv
module egs_sequencer
    import egs_pkg::*;
#(
    parameter int CYCLE_LEN = 1620000,
    parameter int DEPTH     = 64,
    localparam int CNT_W    = $clog2(CYCLE_LEN),
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       dbus_in,
    input  logic             seq_wr_en,
    input  logic [IDX_W-1:0] seq_wr_idx,
    input  logic             seq_wr_valid,
    input  logic [CNT_W-1:0] seq_wr_offset,
    input  logic [7:0]       seq_wr_code,
    output logic [7:0]       ev_code,
    output logic [7:0]       dbus_out,
    output logic             cycle_start,
    output logic             collision
);
    logic [CNT_W-1:0] slot;
    phase_e           phase;
    logic             hit;
    evcode_t          hit_code;
    logic             multi;

    egs_divider #(.CYCLE_LEN(CYCLE_LEN), .CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .slot_o  (slot),
        .phase_o (phase)
    );

    egs_seq_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tab (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (seq_wr_en),
        .wr_idx    (seq_wr_idx),
        .wr_valid  (seq_wr_valid),
        .wr_offset (seq_wr_offset),
        .wr_code   (seq_wr_code),
        .slot      (slot),
        .hit       (hit),
        .hit_code  (hit_code),
        .multi     (multi)
    );

    egs_frame_out u_out (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .hit         (hit),
        .hit_code    (hit_code),
        .multi       (multi),
        .dbus_in     (dbus_in),
        .ev_code     (ev_code),
        .dbus_out    (dbus_out),
        .cycle_start (cycle_start),
        .collision   (collision)
    );
endmodule

// File: rtl/egs_sequencer_chk.sv
module egs_sequencer_chk #(
    parameter int CYCLE_LEN = 1620000
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] dbus_in,
    input logic [7:0] ev_code,
    input logic [7:0] dbus_out,
    input logic       cycle_start,
    input logic       collision
);
    localparam int PW = $clog2(CYCLE_LEN) + 1;

    logic [PW-1:0] since_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (cycle_start) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else begin
            since_q <= since_q + PW'(1);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (ev_code == 8'h00 && dbus_out == 8'h00 && !cycle_start && !collision));

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && seen_q) |-> (since_q == PW'(CYCLE_LEN - 1)));

    assert_marker_code_R3: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (ev_code == 8'h7F));

    assert_collision_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        collision |=> collision);

    assert_dbus_follow_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dbus_out == $past(dbus_in)));
endmodule

bind egs_sequencer egs_sequencer_chk #(.CYCLE_LEN(CYCLE_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbus_in     (dbus_in),
    .ev_code     (ev_code),
    .dbus_out    (dbus_out),
    .cycle_start (cycle_start),
    .collision   (collision)
);

// File: tb/tb_egs_sequencer.sv
module tb_egs_sequencer;
    localparam int LEN   = 20;
    localparam int DEPTH = 8;
    localparam int NWR   = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] dbus_in = 8'h00;
    logic       seq_wr_en = 1'b0;
    logic [2:0] seq_wr_idx = '0;
    logic       seq_wr_valid = 1'b0;
    logic [4:0] seq_wr_offset = '0;
    logic [7:0] seq_wr_code = '0;
    logic [7:0] ev_code, dbus_out;
    logic       cycle_start, collision;

    int total = 0;
    int fails = 0;

    logic       sh_v   [DEPTH];
    logic [4:0] sh_off [DEPTH];
    logic [7:0] sh_code[DEPTH];
    logic       exp_coll = 1'b0;
    logic [7:0] last_db;

    // {idx, valid, offset, code}
    localparam logic [16:0] WR_TAB [NWR] = '{
        {3'd0, 1'b1, 5'd3,  8'h11},
        {3'd1, 1'b1, 5'd7,  8'h22},
        {3'd2, 1'b1, 5'd19, 8'h33},
        {3'd3, 1'b0, 5'd5,  8'h44},
        {3'd4, 1'b1, 5'd1,  8'h55},
        {3'd5, 1'b1, 5'd25, 8'h66},
        {3'd6, 1'b1, 5'd12, 8'hA5}
    };

    always #10 clk = ~clk;

    egs_sequencer #(.CYCLE_LEN(LEN), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .dbus_in(dbus_in),
        .seq_wr_en(seq_wr_en), .seq_wr_idx(seq_wr_idx), .seq_wr_valid(seq_wr_valid),
        .seq_wr_offset(seq_wr_offset), .seq_wr_code(seq_wr_code),
        .ev_code(ev_code), .dbus_out(dbus_out),
        .cycle_start(cycle_start), .collision(collision)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_code(input int s);
        if (s == 0) return 8'h7F;
        for (int i = 0; i < DEPTH; i++)
            if (sh_v[i] && int'(sh_off[i]) == s) return sh_code[i];
        return 8'h00;
    endfunction

    function automatic logic model_coll();
        for (int s = 0; s < LEN; s++) begin
            int n = 0;
            for (int i = 0; i < DEPTH; i++)
                if (sh_v[i] && int'(sh_off[i]) == s) n++;
            if ((s == 0 && n > 0) || n > 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic write_entry(input logic [2:0] idx, input logic v,
                               input logic [4:0] off, input logic [7:0] code);
        seq_wr_en = 1'b1; seq_wr_idx = idx; seq_wr_valid = v;
        seq_wr_offset = off; seq_wr_code = code;
        @(negedge clk);
        seq_wr_en = 1'b0;
        sh_v[idx] = v; sh_off[idx] = off; sh_code[idx] = code;
    endtask

    task automatic sync_start();
        @(negedge clk);
        for (int k = 0; k < 4 * LEN && !cycle_start; k++) @(negedge clk);
    endtask

    // expects to be called at the negedge where cycle_start is visible
    task automatic run_cycle(input string coll_tag, input logic [7:0] salt);
        logic [7:0] e;
        exp_coll = exp_coll | model_coll();
        last_db = dbus_in;
        for (int s = 0; s < LEN; s++) begin
            e = model_code(s);
            if (s == 0)            chk("R3", ev_code, e);
            else if (e != 8'h00)   chk("R4", ev_code, e);
            else                   chk("R5", ev_code, e);
            chk("R2", cycle_start, (s == 0));
            chk("R8", dbus_out, last_db);
            if (s == LEN - 1) chk(coll_tag, collision, exp_coll);
            dbus_in = 8'(s * 37) ^ salt;
            last_db = dbus_in;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dbus_in = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        chk("R1", ev_code, 8'h00);
        chk("R1", dbus_out, 8'h00);
        chk("R1", cycle_start, 0);
        chk("R1", collision, 0);
        for (int i = 0; i < DEPTH; i++) sh_v[i] = 1'b0;
        exp_coll = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", cycle_start, 0);
        @(negedge clk);
        chk("R1", cycle_start, 1);
        chk("R3", ev_code, 8'h7F);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sh_v[i] = 1'b0; sh_off[i] = '0; sh_code[i] = '0;
        end
        do_reset();

        // table walk: R4, R5, R9 (disabled entry, offset beyond cycle), R10
        for (int w = 0; w < NWR; w++)
            write_entry(WR_TAB[w][16:14], WR_TAB[w][13], WR_TAB[w][12:8], WR_TAB[w][7:0]);
        @(negedge clk);
        sync_start();
        run_cycle("R10", 8'h3C);
        run_cycle("R10", 8'hC3);   // back-to-back cycles: R2 period

        // R6: duplicate offset, lower index wins and flag sets
        write_entry(3'd7, 1'b1, 5'd7, 8'h99);
        @(negedge clk);
        sync_start();
        run_cycle("R6", 8'h5A);

        // R9 + R6: disabling idx1 lets idx7 through; flag stays set
        write_entry(3'd1, 1'b0, 5'd7, 8'h22);
        @(negedge clk);
        sync_start();
        run_cycle("R6", 8'hF0);

        // R1: reset clears table and flag; R5 empty cycle
        do_reset();
        run_cycle("R10", 8'h0F);

        // R7: entry at offset 0 never emits, marker wins, flag set
        write_entry(3'd2, 1'b1, 5'd0, 8'h42);
        @(negedge clk);
        sync_start();
        run_cycle("R7", 8'h81);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule